// File: doc/BRIEF.md
# Quadword Add/Subtract Carry Unit

This block does unsigned integer arithmetic on 128-bit quadwords for a vector execution pipe. It decodes a 32-bit instruction word and handles eight forms. There are four add forms and four subtract forms. For each of add and subtract there is a modulo result, a carry result, an extended modulo result that takes a carry-in, and an extended carry result. The operands are A, B and C. For the extended forms only bit 0 of C is used, as the carry-in.

A one-cycle `start` pulse presents the instruction word and the operands. One clock later the unit raises one of two flags. `valid` means the registered 128-bit result holds the new value. `illegal` means the word matched none of the eight encodings, and in that case the result register keeps its old value. Every form runs through one shared 129-bit adder. The adder's top bit is the carry.

Top module: `qw_addsub_unit`

## Requirements
- R1: A word with bits [31:26] = 000100 and bits [10:0] equal to one of these values runs the named operation: 00100000000 modulo add, 00101000000 add carry, 10100000000 modulo subtract, 10101000000 subtract carry.
- R2: A word with bits [31:26] = 000100 whose bits [10:0] match none of the R1 values, and whose bits [5:0] equal one of these values, runs the named extended operation: 111100 modulo add, 111101 add carry, 111110 modulo subtract, 111111 subtract carry.
- R3: Any other word, given with `start`, sets `illegal` for exactly one cycle on the following cycle. In that cycle `valid` stays low and `result` keeps its previous value.
- R4: `valid` and `illegal` are high only in the cycle after a `start` cycle. For a legal word, `valid` is high and `result` carries the new value in that cycle.
- R5: Modulo add gives (A + B) mod 2^128.
- R6: Modulo subtract gives (A + ~B + 1) mod 2^128. The extended forms add a carry-in in place of the fixed 1, and the extended add gives (A + B + cin) mod 2^128.
- R7: For the extended forms the carry-in is C[0]. Bits [127:1] of C have no effect. The plain forms ignore C entirely.
- R8: A carry form puts the carry in result bit 0 and zeros in bits [127:1].
- R9: The subtract carry is 1 when there is no borrow. For the plain form that is A >= B unsigned. For the extended form it is A > B, or A == B with carry-in 1.
- R10: The add carry is 1 when A + B overflows 128 bits. For the extended form it is also 1 when the carry-in is 1 and A + B equals all ones.
- R11: Synchronous reset clears `result`, `valid` and `illegal` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Presents insn and operands for one cycle |
| insn | input | 32 | Instruction word |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| opc | input | 128 | Operand C (bit 0 is the carry-in for the extended forms) |
| result | output | 128 | Registered result |
| valid | output | 1 | Result updated this cycle |
| illegal | output | 1 | Instruction word was not recognised |

## Verification
The bench concentrates on the carry boundaries where the wrong formula still gives plausible answers:
- **All-ones plus one.** This must wrap to zero with a carry of 1. A design that drops the carry would return 0 for the carry form.
- **A + B exactly all ones, carry-in 1.** The extended add carry must be 1. A design that checks only A + B for overflow would report 0.
- **A == B in subtraction.** The plain form must give a carry of 1. The extended form must give the carry-in value. A design that used a fixed carry-in, or compared with `>`, would get one of these wrong.

Three further groups of stimulus:
- Words with wrong primary bits and wrong minor fields must raise the illegal flag and leave the old result in place. A decoder that falls through to a default operation would instead overwrite the result.
- Operand C carries junk in its upper bits, so any use of those bits changes the result.
- Plain forms receive a C with bit 0 set, so any leak of a carry-in into them also changes the result.

// File: rtl/qw_pkg.sv
package qw_pkg;

    localparam int INSN_W      = 32;
    localparam int PRIMARY_W   = 6;
    localparam int MINOR_W     = 11;
    localparam int XFIELD_W    = 6;

    localparam logic [PRIMARY_W-1:0] PRIMARY_VEC = 6'b000100;

    localparam logic [MINOR_W-1:0] MINOR_ADD  = 11'b00100000000;
    localparam logic [MINOR_W-1:0] MINOR_ADDC = 11'b00101000000;
    localparam logic [MINOR_W-1:0] MINOR_SUB  = 11'b10100000000;
    localparam logic [MINOR_W-1:0] MINOR_SUBC = 11'b10101000000;

    localparam logic [XFIELD_W-1:0] XF_ADD  = 6'b111100;
    localparam logic [XFIELD_W-1:0] XF_ADDC = 6'b111101;
    localparam logic [XFIELD_W-1:0] XF_SUB  = 6'b111110;
    localparam logic [XFIELD_W-1:0] XF_SUBC = 6'b111111;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADD,
        OP_ADDC,
        OP_SUB,
        OP_SUBC,
        OP_XADD,
        OP_XADDC,
        OP_XSUB,
        OP_XSUBC
    } qw_op_e;

    typedef struct packed {
        logic legal;
        logic subtract;
        logic extended;
        logic carry_only;
    } qw_ctrl_t;

    function automatic qw_ctrl_t op_to_ctrl(qw_op_e op);
        qw_ctrl_t c;
        c = '0;
        unique case (op)
            OP_ADD:   c = '{legal: 1'b1, subtract: 1'b0, extended: 1'b0, carry_only: 1'b0};
            OP_ADDC:  c = '{legal: 1'b1, subtract: 1'b0, extended: 1'b0, carry_only: 1'b1};
            OP_SUB:   c = '{legal: 1'b1, subtract: 1'b1, extended: 1'b0, carry_only: 1'b0};
            OP_SUBC:  c = '{legal: 1'b1, subtract: 1'b1, extended: 1'b0, carry_only: 1'b1};
            OP_XADD:  c = '{legal: 1'b1, subtract: 1'b0, extended: 1'b1, carry_only: 1'b0};
            OP_XADDC: c = '{legal: 1'b1, subtract: 1'b0, extended: 1'b1, carry_only: 1'b1};
            OP_XSUB:  c = '{legal: 1'b1, subtract: 1'b1, extended: 1'b1, carry_only: 1'b0};
            OP_XSUBC: c = '{legal: 1'b1, subtract: 1'b1, extended: 1'b1, carry_only: 1'b1};
            default:  c = '0;
        endcase
        return c;
    endfunction

    // Carry-in for the adder: extended forms take the C operand bit,
    // plain subtract injects the +1 of two's complement, plain add none.
    function automatic logic pick_carry_in(qw_ctrl_t c, logic c_bit);
        logic ci;
        if (c.extended)
            ci = c_bit;
        else
            ci = c.subtract;
        return ci;
    endfunction

endpackage

// File: rtl/qw_decoder.sv
module qw_decoder
    import qw_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output qw_ctrl_t          ctrl
);

    localparam int PRI_LO = INSN_W - PRIMARY_W;

    logic [PRIMARY_W-1:0] primary;
    logic [MINOR_W-1:0]   minor;
    logic [XFIELD_W-1:0]  xfield;
    logic                 unused_reg_fields;
    qw_op_e               op;

    assign primary = insn[INSN_W-1:PRI_LO];
    assign minor   = insn[MINOR_W-1:0];
    assign xfield  = insn[XFIELD_W-1:0];
    // Register-number fields select storage outside this unit.
    assign unused_reg_fields = ^insn[PRI_LO-1:MINOR_W];

    always_comb begin
        op = OP_NONE;
        if (primary == PRIMARY_VEC) begin
            unique case (minor)
                MINOR_ADD:  op = OP_ADD;
                MINOR_ADDC: op = OP_ADDC;
                MINOR_SUB:  op = OP_SUB;
                MINOR_SUBC: op = OP_SUBC;
                default: begin
                    unique case (xfield)
                        XF_ADD:  op = OP_XADD;
                        XF_ADDC: op = OP_XADDC;
                        XF_SUB:  op = OP_XSUB;
                        XF_SUBC: op = OP_XSUBC;
                        default: op = OP_NONE;
                    endcase
                end
            endcase
        end
    end

    assign ctrl = op_to_ctrl(op);

endmodule

// File: rtl/qw_operand_prep.sv
module qw_operand_prep
    import qw_pkg::*;
#(
    parameter int WIDTH = 128
) (
    input  qw_ctrl_t         ctrl,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             cin
);

    logic unused_c_high;

    assign unused_c_high = ^c[WIDTH-1:1];
    assign add_x = a;
    assign add_y = ctrl.subtract ? ~b : b;
    assign cin   = pick_carry_in(ctrl, c[0]);

endmodule

// File: rtl/qw_adder.sv
module qw_adder #(
    parameter int WIDTH = 128
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] full;

    assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    assign sum  = full[WIDTH-1:0];
    assign cout = full[EXT_W-1];

endmodule

// File: rtl/qw_result_fmt.sv
module qw_result_fmt #(
    parameter int WIDTH = 128
) (
    input  logic             carry_only,
    input  logic [WIDTH-1:0] sum,
    input  logic             cout,
    output logic [WIDTH-1:0] value
);

    always_comb begin
        if (carry_only)
            value = {{(WIDTH-1){1'b0}}, cout};
        else
            value = sum;
    end

endmodule

// File: rtl/qw_addsub_unit.sv
module qw_addsub_unit
    import qw_pkg::*;
#(
    parameter int WIDTH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       insn,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic [WIDTH-1:0]  opc,
    output logic [WIDTH-1:0]  result,
    output logic              valid,
    output logic              illegal
);

    qw_ctrl_t         dec_ctrl;
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic [WIDTH-1:0] next_value;

    qw_decoder u_dec (
        .insn (insn),
        .ctrl (dec_ctrl)
    );

    qw_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .ctrl  (dec_ctrl),
        .a     (opa),
        .b     (opb),
        .c     (opc),
        .add_x (add_x),
        .add_y (add_y),
        .cin   (add_cin)
    );

    qw_adder #(.WIDTH(WIDTH)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    qw_result_fmt #(.WIDTH(WIDTH)) u_fmt (
        .carry_only (dec_ctrl.carry_only),
        .sum        (add_sum),
        .cout       (add_cout),
        .value      (next_value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            valid   <= 1'b0;
            illegal <= 1'b0;
        end else begin
            valid   <= start && dec_ctrl.legal;
            illegal <= start && !dec_ctrl.legal;
            if (start && dec_ctrl.legal)
                result <= next_value;
        end
    end

endmodule

// File: rtl/qw_addsub_checker.sv
module qw_addsub_checker #(
    parameter int WIDTH = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             legal,
    input logic             carry_only,
    input logic [WIDTH-1:0] result,
    input logic             valid,
    input logic             illegal
);

    // R4: a valid result only follows a start cycle
    p_valid_after_start_r4: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(start));

    // R4: the illegal flag only follows a start cycle
    p_illegal_after_start_r4: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $past(start));

    // R3: an unrecognised word raises the flag on the next cycle
    p_flag_unknown_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !legal) |=> (illegal && !valid));

    // R3: the result register holds when the word is rejected
    p_hold_on_illegal_r3: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(result));

    // R3: the two outcomes never coincide
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(valid && illegal));

    // R8: carry forms leave only bit 0 possibly set
    p_carry_upper_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(carry_only)) |-> (result[WIDTH-1:1] == '0));

endmodule

bind qw_addsub_unit qw_addsub_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .legal      (dec_ctrl.legal),
    .carry_only (dec_ctrl.carry_only),
    .result     (result),
    .valid      (valid),
    .illegal    (illegal)
);

// File: tb/qw_addsub_unit_tb.sv
module qw_addsub_unit_tb;

    localparam int W = 128;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    typedef struct {
        logic         is_illegal;
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [31:0]   insn;
    logic [W-1:0]  opa, opb, opc;
    logic [W-1:0]  result;
    logic          valid, illegal;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    item_t sb[$];
    logic [W-1:0] model_res;

    always #5 clk = ~clk;

    qw_addsub_unit #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .insn(insn),
        .opa(opa), .opb(opb), .opc(opc),
        .result(result), .valid(valid), .illegal(illegal)
    );

    function automatic logic [31:0] vx(input logic [10:0] minor);
        return {6'b000100, 5'd7, 5'd1, 5'd2, minor};
    endfunction

    function automatic logic [31:0] va(input logic [5:0] xf);
        return {6'b000100, 5'd7, 5'd1, 5'd2, 5'd3, xf};
    endfunction

    // Reference built from the requirements with 129-bit arithmetic
    task automatic ref_model(input logic [31:0] w, input logic [W-1:0] a,
                             input logic [W-1:0] b, input logic [W-1:0] c,
                             output logic ok, output logic [W-1:0] r);
        logic [W:0] s;
        logic ci;
        ok = 1'b1;
        r  = '0;
        ci = c[0];
        s  = {1'b0, a} + {1'b0, b};
        if (w[31:26] != 6'b000100) ok = 1'b0;
        else if (w[10:0] == 11'b00100000000) r = s[W-1:0];
        else if (w[10:0] == 11'b00101000000) r = {{(W-1){1'b0}}, s[W]};
        else if (w[10:0] == 11'b10100000000) r = a - b;
        else if (w[10:0] == 11'b10101000000) r = {{(W-1){1'b0}}, (a >= b)};
        else if (w[5:0] == 6'b111100) r = a + b + {{(W-1){1'b0}}, ci};
        else if (w[5:0] == 6'b111101)
            r = {{(W-1){1'b0}}, (s[W] || (ci && s[W-1:0] == ONES))};
        else if (w[5:0] == 6'b111110) r = a - b - {{(W-1){1'b0}}, !ci};
        else if (w[5:0] == 6'b111111)
            r = {{(W-1){1'b0}}, ((a > b) || (ci && a == b))};
        else ok = 1'b0;
    endtask

    task automatic issue(input logic [31:0] w, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] c,
                         input string tag);
        item_t it;
        logic ok;
        logic [W-1:0] r;
        @(negedge clk);
        start = 1'b1; insn = w; opa = a; opb = b; opc = c;
        ref_model(w, a, b, c, ok, r);
        it.is_illegal = !ok;
        it.tag = tag;
        if (ok) begin
            model_res = r;
            it.exp = r;
        end else begin
            it.exp = model_res;
        end
        sb.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares each produced outcome with the queued expectation
    always @(negedge clk) begin
        if (!rst && (valid || illegal)) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected output: valid=%0b illegal=%0b expected none",
                         valid, illegal);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (valid != !it.is_illegal || illegal != it.is_illegal || result != it.exp) begin
                    errors++;
                    $display("FAIL %s: valid=%0b illegal=%0b result=%h expected valid=%0b illegal=%0b result=%h",
                             it.tag, valid, illegal, result, !it.is_illegal, it.is_illegal, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] big;
        rst = 1'b1; start = 1'b0; insn = '0; opa = '0; opb = '0; opc = '0;
        model_res = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (result != '0 || valid || illegal) begin
            errors++;
            $display("FAIL R11 reset: result=%h valid=%0b illegal=%0b expected 0 0 0",
                     result, valid, illegal);
        end
        rst = 1'b0;

        // R1 R5: modulo add, simple and wrapping; C bit 0 set must not matter (R7)
        issue(vx(11'b00100000000), 128'd1, 128'd2, 128'd1, "R5 add 1+2");
        issue(vx(11'b00100000000), ONES, 128'd1, 128'd1, "R5 add wrap");
        // R8 R10: add carry
        issue(vx(11'b00101000000), ONES, 128'd1, '0, "R10 add carry overflow");
        issue(vx(11'b00101000000), '0, '0, '0, "R10 add carry zero");
        issue(vx(11'b00101000000), ONES, '0, ONES, "R10 plain all-ones no carry");
        // R6: subtract
        issue(vx(11'b10100000000), 128'd5, 128'd3, '0, "R6 sub 5-3");
        issue(vx(11'b10100000000), 128'd3, 128'd5, '0, "R6 sub wrap");
        // R9: subtract carry
        issue(vx(11'b10101000000), 128'd9, 128'd9, '0, "R9 subc equal");
        issue(vx(11'b10101000000), 128'd3, 128'd9, '0, "R9 subc borrow");
        issue(vx(11'b10101000000), ONES, '0, '0, "R9 subc greater");
        drain();

        // R2 R7: extended add, carry-in from C bit 0 only
        issue(va(6'b111100), 128'd10, 128'd20, {{(W-1){1'b1}}, 1'b0}, "R7 xadd cin0 junk C");
        issue(va(6'b111100), 128'd10, 128'd20, 128'h8000_0000_0000_0000_0000_0000_0000_0001, "R7 xadd cin1 junk C");
        issue(va(6'b111100), ONES, '0, 128'd1, "R6 xadd wrap");
        // R10: extended add carry
        big = 128'h0123_4567_89ab_cdef_0011_2233_4455_6677;
        issue(va(6'b111101), big, ~big, 128'd1, "R10 xaddc all-ones cin1");
        issue(va(6'b111101), big, ~big, 128'd0, "R10 xaddc all-ones cin0");
        issue(va(6'b111101), '0, '0, 128'd1, "R10 xaddc zeros cin1");
        issue(va(6'b111101), ONES, ONES, 128'd0, "R10 xaddc overflow");
        // R6 R9: extended subtract
        issue(va(6'b111110), 128'd100, 128'd1, 128'd0, "R6 xsub cin0");
        issue(va(6'b111110), 128'd100, 128'd1, 128'd1, "R6 xsub cin1");
        issue(va(6'b111111), big, big, 128'd0, "R9 xsubc equal cin0");
        issue(va(6'b111111), big, big, 128'd1, "R9 xsubc equal cin1");
        issue(va(6'b111111), big, big - 1, 128'd0, "R9 xsubc greater");
        drain();

        // R3: unknown words keep the previous result
        issue(vx(11'b00100000000), 128'hdead_beef, 128'd1, '0, "R1 add before illegal");
        issue({6'b000101, 15'd0, 11'b00100000000}, 128'd1, 128'd1, '0, "R3 bad primary");
        issue(vx(11'b00100000001), 128'd1, 128'd1, '0, "R3 bad minor");
        issue(va(6'b111011), 128'd1, 128'd1, '0, "R3 bad extended field");
        drain();

        // R4: no start, no output
        insn = vx(11'b00100000000); opa = 128'd4; opb = 128'd4;
        repeat (2) @(negedge clk);
        checks++;
        if (valid || illegal || result != model_res) begin
            errors++;
            $display("FAIL R4 idle: valid=%0b illegal=%0b result=%h expected 0 0 %h",
                     valid, illegal, result, model_res);
        end

        // R1 R2: mixed back-to-back stream
        for (int i = 0; i < 48; i++) begin
            logic [31:0] w;
            logic [W-1:0] a, b, c;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            c = {$urandom, $urandom, $urandom, $urandom};
            if (i % 6 == 0) b = ~a;
            if (i % 6 == 1) b = a;
            case (i % 8)
                0: w = vx(11'b00100000000);
                1: w = vx(11'b00101000000);
                2: w = vx(11'b10100000000);
                3: w = vx(11'b10101000000);
                4: w = va(6'b111100);
                5: w = va(6'b111101);
                6: w = va(6'b111110);
                default: w = va(6'b111111);
            endcase
            issue(w, a, b, c, "R1 R2 stream");
        end
        drain();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R4 missing outputs: pending=%0d expected 0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule